// File: doc/BRIEF.md
# Power-Up Boot Sequencer

This block brings a small audio processing core from reset to a usable state. When reset is released it first waits out a fixed settling period for the clock generator. It then copies the program boot ROM into program RAM word by word and copies the parameter boot ROM, whose contents are all zeros, into parameter RAM. Last, it writes zeros through the whole data memory and pulses a strobe that clears the control registers. After that it raises a done flag and keeps it high until the next reset.

While the sequence runs, a busy flag is high. Every host control-port request that arrives before done is refused, and the refusal is flagged one cycle later. Requests are granted only after done. The clock-mode select inputs are captured when reset is released and held steady from then on. A new reset in any phase abandons the sequence at once. Once that reset is released, the whole sequence starts again from the settling wait.

The settling count and the three memory depths are parameters, so a short configuration can be used for test.

Top module: `boot_sequencer`

## Requirements
- R1: While reset is held, done_o, busy_o, reg_clr_o and all three RAM write enables are 0, and a host request made then is answered with host_refused_o=1 and host_grant_o=0.
- R2: rst_i is sampled on the falling edge of clk_i. The sequence starts at the first rising edge that follows a falling edge which saw rst_i low, and busy_o is 1 from that edge on. A release made just after a falling edge starts the sequence one cycle later than a release made just after a rising edge.
- R3: The settling wait lasts exactly LOCK_CYCLES cycles from the start edge. After that the program ROM is read from address 0. The first program RAM write (address 0) appears one cycle later, and there are no program RAM writes during the wait.
- R4: Program RAM receives exactly PROG_DEPTH writes, at addresses 0 to PROG_DEPTH-1 in rising order. Each write carries the word that the program ROM returned for that address, one cycle after the address was presented.
- R5: Parameter RAM receives exactly PARAM_DEPTH writes, at addresses 0 to PARAM_DEPTH-1 in rising order. Each carries the parameter ROM word for that address, which is 0.
- R6: Data RAM receives exactly DATA_DEPTH writes of zero, at addresses 0 to DATA_DEPTH-1 in rising order. reg_clr_o is high for exactly one cycle per sequence, in the first cycle of the data clear, which is LOCK_CYCLES+PROG_DEPTH+PARAM_DEPTH cycles after the start edge.
- R7: done_o rises exactly LOCK_CYCLES+PROG_DEPTH+PARAM_DEPTH+DATA_DEPTH cycles after the start edge, with busy_o falling in the same cycle. done_o then stays high until reset, and no RAM write occurs while it is high.
- R8: A host request in one cycle is answered in the next cycle. The answer is host_grant_o=1 if done_o was high, and host_refused_o=1 otherwise. The two are never high together.
- R9: clk_mode_o holds the value clk_mode_i had at the start edge and does not change for the rest of the sequence, whatever clk_mode_i does.
- R10: Reset asserted during the sequence returns the block to its reset state (done_o=0, busy_o=0, no writes) at the first rising edge after the falling edge that samples it. After release, the complete sequence runs again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Active-high reset, captured on the falling clock edge |
| clk_mode_i | input | 2 | Clock-mode select |
| clk_mode_o | output | 2 | Clock-mode value captured at reset release |
| prog_rom_addr_o | output | clog2(PROG_DEPTH) | Program boot ROM read address |
| prog_rom_data_i | input | PROG_DW | Program boot ROM data, one cycle after the address |
| prog_ram_we_o | output | 1 | Program RAM write enable |
| prog_ram_addr_o | output | clog2(PROG_DEPTH) | Program RAM write address |
| prog_ram_wdata_o | output | PROG_DW | Program RAM write data |
| param_rom_addr_o | output | clog2(PARAM_DEPTH) | Parameter boot ROM read address |
| param_rom_data_i | input | PARAM_DW | Parameter boot ROM data, one cycle after the address |
| param_ram_we_o | output | 1 | Parameter RAM write enable |
| param_ram_addr_o | output | clog2(PARAM_DEPTH) | Parameter RAM write address |
| param_ram_wdata_o | output | PARAM_DW | Parameter RAM write data |
| data_ram_we_o | output | 1 | Data memory write enable |
| data_ram_addr_o | output | clog2(DATA_DEPTH) | Data memory write address |
| data_ram_wdata_o | output | DATA_DW | Data memory write data (zero) |
| reg_clr_o | output | 1 | One-cycle control-register clear strobe |
| host_req_i | input | 1 | Host control-port access request |
| host_grant_o | output | 1 | Request of the previous cycle accepted |
| host_refused_o | output | 1 | Request of the previous cycle refused |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |

## Verification
The bench aims at the phase boundaries. These are the last cycle of the settling wait, the last program word written during the first parameter cycle, and the one-cycle clear strobe. A design that dropped the ROM latency would write each word under the wrong address or lose the final one, and an off-by-one counter would move done a cycle early or late. Releasing reset just after a falling edge instead of a rising edge exposes a design that samples reset on the wrong edge, because its start would not slip by one cycle. An abort in the middle of the copy, followed by a full rerun with a different clock mode, catches designs that keep stale state across a reset or let the captured mode follow the live input.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    // One-hot phase encoding of the boot sequence
    typedef enum logic [5:0] {
        ST_IDLE  = 6'b000001,
        ST_LOCK  = 6'b000010,
        ST_PROG  = 6'b000100,
        ST_PARAM = 6'b001000,
        ST_CLEAR = 6'b010000,
        ST_READY = 6'b100000
    } boot_state_e;

    // Decoded phase flags used by the datapath
    typedef struct packed {
        logic idle;
        logic lock;
        logic prog;
        logic param;
        logic clear;
        logic ready;
    } boot_phase_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to index n entries (at least one)
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic boot_phase_t decode_phase(boot_state_e s);
        boot_phase_t p;
        p.idle  = (s == ST_IDLE);
        p.lock  = (s == ST_LOCK);
        p.prog  = (s == ST_PROG);
        p.param = (s == ST_PARAM);
        p.clear = (s == ST_CLEAR);
        p.ready = (s == ST_READY);
        return p;
    endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_seq_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 262144,
    parameter int unsigned PROG_DEPTH  = 1024,
    parameter int unsigned PARAM_DEPTH = 1024,
    parameter int unsigned DATA_DEPTH  = 2048,
    parameter int unsigned CNT_W       = 18
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output boot_state_e       state_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_DEPTH - 1);
    localparam logic [CNT_W-1:0] PARAM_LAST = CNT_W'(PARAM_DEPTH - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_DEPTH - 1);

    boot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_idx;
    logic             at_last;

    // Terminal count of the phase in progress
    always_comb begin
        case (state_q)
            ST_LOCK:  last_idx = LOCK_LAST;
            ST_PROG:  last_idx = PROG_LAST;
            ST_PARAM: last_idx = PARAM_LAST;
            ST_CLEAR: last_idx = DATA_LAST;
            default:  last_idx = '0;
        endcase
        at_last = (cnt_q == last_idx);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        case (state_q)
            ST_IDLE: begin
                state_d = ST_LOCK;
                cnt_d   = '0;
            end
            ST_LOCK: begin
                if (at_last) begin
                    state_d = ST_PROG;
                    cnt_d   = '0;
                end
            end
            ST_PROG: begin
                if (at_last) begin
                    state_d = ST_PARAM;
                    cnt_d   = '0;
                end
            end
            ST_PARAM: begin
                if (at_last) begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end
            end
            ST_CLEAR: begin
                if (at_last) begin
                    state_d = ST_READY;
                    cnt_d   = '0;
                end
            end
            ST_READY: begin
                cnt_d = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/boot_rom_copy.sv
module boot_rom_copy #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          active_i,
    input  logic [AW-1:0] idx_i,
    output logic [AW-1:0] rom_addr_o,
    input  logic [DW-1:0] rom_data_i,
    output logic          ram_we_o,
    output logic [AW-1:0] ram_addr_o,
    output logic [DW-1:0] ram_wdata_o
);

    logic          we_q;
    logic [AW-1:0] addr_q;

    // ROM is read in the phase cycle; the write follows one cycle later
    assign rom_addr_o = active_i ? idx_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            we_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            we_q   <= active_i;
            addr_q <= idx_i;
        end
    end

    assign ram_we_o    = we_q;
    assign ram_addr_o  = addr_q;
    assign ram_wdata_o = rom_data_i;

endmodule

// File: rtl/boot_host_gate.sv
module boot_host_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    input  logic ready_i,
    output logic grant_o,
    output logic refused_o
);

    logic grant_q;
    logic refused_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            grant_q   <= 1'b0;
            refused_q <= req_i;
        end else begin
            grant_q   <= req_i & ready_i;
            refused_q <= req_i & ~ready_i;
        end
    end

    assign grant_o   = grant_q;
    assign refused_o = refused_q;

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_seq_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 262144,
    parameter int unsigned PROG_DEPTH  = 1024,
    parameter int unsigned PARAM_DEPTH = 1024,
    parameter int unsigned DATA_DEPTH  = 2048,
    parameter int unsigned PROG_DW     = 40,
    parameter int unsigned PARAM_DW    = 28,
    parameter int unsigned DATA_DW     = 28,
    parameter int unsigned MODE_W      = 2
) (
    input  logic                                  clk_i,
    input  logic                                  rst_i,
    input  logic [MODE_W-1:0]                     clk_mode_i,
    output logic [MODE_W-1:0]                     clk_mode_o,
    output logic [idx_width(PROG_DEPTH)-1:0]      prog_rom_addr_o,
    input  logic [PROG_DW-1:0]                    prog_rom_data_i,
    output logic                                  prog_ram_we_o,
    output logic [idx_width(PROG_DEPTH)-1:0]      prog_ram_addr_o,
    output logic [PROG_DW-1:0]                    prog_ram_wdata_o,
    output logic [idx_width(PARAM_DEPTH)-1:0]     param_rom_addr_o,
    input  logic [PARAM_DW-1:0]                   param_rom_data_i,
    output logic                                  param_ram_we_o,
    output logic [idx_width(PARAM_DEPTH)-1:0]     param_ram_addr_o,
    output logic [PARAM_DW-1:0]                   param_ram_wdata_o,
    output logic                                  data_ram_we_o,
    output logic [idx_width(DATA_DEPTH)-1:0]      data_ram_addr_o,
    output logic [DATA_DW-1:0]                    data_ram_wdata_o,
    output logic                                  reg_clr_o,
    input  logic                                  host_req_i,
    output logic                                  host_grant_o,
    output logic                                  host_refused_o,
    output logic                                  busy_o,
    output logic                                  done_o
);

    localparam int unsigned PROG_AW  = idx_width(PROG_DEPTH);
    localparam int unsigned PARAM_AW = idx_width(PARAM_DEPTH);
    localparam int unsigned DATA_AW  = idx_width(DATA_DEPTH);
    localparam int unsigned CNT_W    =
        idx_width(max2(max2(LOCK_CYCLES, PROG_DEPTH), max2(PARAM_DEPTH, DATA_DEPTH)));

    logic              rst_s;
    boot_state_e       state;
    boot_phase_t       ph;
    logic [CNT_W-1:0]  cnt;
    logic [MODE_W-1:0] mode_q;

    // Reset is taken on the falling edge of the master clock
    always_ff @(negedge clk_i) begin
        rst_s <= rst_i;
    end

    boot_seq_fsm #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .PROG_DEPTH  (PROG_DEPTH),
        .PARAM_DEPTH (PARAM_DEPTH),
        .DATA_DEPTH  (DATA_DEPTH),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_s),
        .state_o (state),
        .cnt_o   (cnt)
    );

    assign ph = decode_phase(state);

    // Clock mode follows the input only while waiting in reset
    always_ff @(posedge clk_i) begin
        if (ph.idle) begin
            mode_q <= clk_mode_i;
        end
    end
    assign clk_mode_o = mode_q;

    boot_rom_copy #(
        .AW (PROG_AW),
        .DW (PROG_DW)
    ) u_prog_copy (
        .clk_i       (clk_i),
        .rst_i       (rst_s),
        .active_i    (ph.prog),
        .idx_i       (cnt[PROG_AW-1:0]),
        .rom_addr_o  (prog_rom_addr_o),
        .rom_data_i  (prog_rom_data_i),
        .ram_we_o    (prog_ram_we_o),
        .ram_addr_o  (prog_ram_addr_o),
        .ram_wdata_o (prog_ram_wdata_o)
    );

    boot_rom_copy #(
        .AW (PARAM_AW),
        .DW (PARAM_DW)
    ) u_param_copy (
        .clk_i       (clk_i),
        .rst_i       (rst_s),
        .active_i    (ph.param),
        .idx_i       (cnt[PARAM_AW-1:0]),
        .rom_addr_o  (param_rom_addr_o),
        .rom_data_i  (param_rom_data_i),
        .ram_we_o    (param_ram_we_o),
        .ram_addr_o  (param_ram_addr_o),
        .ram_wdata_o (param_ram_wdata_o)
    );

    // Data memory needs no source: zeros are written directly
    assign data_ram_we_o    = ph.clear;
    assign data_ram_addr_o  = cnt[DATA_AW-1:0];
    assign data_ram_wdata_o = '0;

    assign reg_clr_o = ph.clear && (cnt == '0);

    boot_host_gate u_host (
        .clk_i     (clk_i),
        .rst_i     (rst_s),
        .req_i     (host_req_i),
        .ready_i   (ph.ready),
        .grant_o   (host_grant_o),
        .refused_o (host_refused_o)
    );

    assign busy_o = ph.lock | ph.prog | ph.param | ph.clear;
    assign done_o = ph.ready;

endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk #(
    parameter int unsigned PROG_AW  = 10,
    parameter int unsigned PARAM_AW = 10,
    parameter int unsigned MODE_W   = 2
) (
    input logic                clk_i,
    input logic                rst_s,
    input logic                done_o,
    input logic                busy_o,
    input logic                reg_clr_o,
    input logic                prog_ram_we_o,
    input logic [PROG_AW-1:0]  prog_ram_addr_o,
    input logic                param_ram_we_o,
    input logic [PARAM_AW-1:0] param_ram_addr_o,
    input logic                data_ram_we_o,
    input logic                host_grant_o,
    input logic                host_refused_o,
    input logic [MODE_W-1:0]   clk_mode_o
);

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        (rst_s === 1'b1) |=> (!done_o && !busy_o && !prog_ram_we_o && !param_ram_we_o && !data_ram_we_o));

    assert_prog_ascend_R4: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        (prog_ram_we_o && $past(prog_ram_we_o)) |-> (prog_ram_addr_o == PROG_AW'($past(prog_ram_addr_o) + 1'b1)));

    assert_param_ascend_R5: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        (param_ram_we_o && $past(param_ram_we_o)) |-> (param_ram_addr_o == PARAM_AW'($past(param_ram_addr_o) + 1'b1)));

    assert_clear_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        reg_clr_o |=> !reg_clr_o);

    assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        done_o |=> done_o);

    assert_quiet_after_done_R7: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        done_o |-> !(prog_ram_we_o || param_ram_we_o || data_ram_we_o || busy_o));

    assert_grant_after_done_R8: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        host_grant_o |-> ($past(done_o) && !host_refused_o));

    assert_mode_held_R9: assert property (@(posedge clk_i) disable iff (rst_s !== 1'b0)
        (busy_o && $past(busy_o)) |-> $stable(clk_mode_o));

endmodule

bind boot_sequencer boot_sequencer_chk #(
    .PROG_AW  (PROG_AW),
    .PARAM_AW (PARAM_AW),
    .MODE_W   (MODE_W)
) u_chk (
    .clk_i            (clk_i),
    .rst_s            (rst_s),
    .done_o           (done_o),
    .busy_o           (busy_o),
    .reg_clr_o        (reg_clr_o),
    .prog_ram_we_o    (prog_ram_we_o),
    .prog_ram_addr_o  (prog_ram_addr_o),
    .param_ram_we_o   (param_ram_we_o),
    .param_ram_addr_o (param_ram_addr_o),
    .data_ram_we_o    (data_ram_we_o),
    .host_grant_o     (host_grant_o),
    .host_refused_o   (host_refused_o),
    .clk_mode_o       (clk_mode_o)
);

// File: tb/tb_boot_sequencer.sv
module tb_boot_sequencer;

    localparam int unsigned L  = 20;
    localparam int unsigned PD = 8;
    localparam int unsigned QD = 6;
    localparam int unsigned DD = 5;
    localparam int unsigned N  = L + PD + QD + DD;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_in;
    logic [1:0]  mode_out;
    logic [2:0]  prog_rom_addr, prog_ram_addr;
    logic [15:0] prog_rom_q, prog_wdata;
    logic        prog_we;
    logic [2:0]  param_rom_addr, param_ram_addr;
    logic [11:0] param_rom_q, param_wdata;
    logic        param_we;
    logic        data_we;
    logic [2:0]  data_addr;
    logic [11:0] data_wdata;
    logic        reg_clr, host_req, grant, refused, busy, done;

    int total = 0;
    int bad   = 0;
    int clr_seen = 0;
    bit track = 1'b0;
    logic [31:0] prog_exp[$];
    logic [31:0] param_exp[$];
    logic [31:0] data_exp[$];

    always #10 clk = ~clk;

    boot_sequencer #(
        .LOCK_CYCLES (L),
        .PROG_DEPTH  (PD),
        .PARAM_DEPTH (QD),
        .DATA_DEPTH  (DD),
        .PROG_DW     (16),
        .PARAM_DW    (12),
        .DATA_DW     (12),
        .MODE_W      (2)
    ) dut (
        .clk_i             (clk),
        .rst_i             (rst),
        .clk_mode_i        (mode_in),
        .clk_mode_o        (mode_out),
        .prog_rom_addr_o   (prog_rom_addr),
        .prog_rom_data_i   (prog_rom_q),
        .prog_ram_we_o     (prog_we),
        .prog_ram_addr_o   (prog_ram_addr),
        .prog_ram_wdata_o  (prog_wdata),
        .param_rom_addr_o  (param_rom_addr),
        .param_rom_data_i  (param_rom_q),
        .param_ram_we_o    (param_we),
        .param_ram_addr_o  (param_ram_addr),
        .param_ram_wdata_o (param_wdata),
        .data_ram_we_o     (data_we),
        .data_ram_addr_o   (data_addr),
        .data_ram_wdata_o  (data_wdata),
        .reg_clr_o         (reg_clr),
        .host_req_i        (host_req),
        .host_grant_o      (grant),
        .host_refused_o    (refused),
        .busy_o            (busy),
        .done_o            (done)
    );

    function automatic logic [15:0] rom_word(logic [2:0] a);
        return 16'(({13'd0, a} * 16'h1357) ^ 16'hA5C3);
    endfunction

    // Boot ROM models with one cycle of read latency
    always @(posedge clk) begin
        prog_rom_q  <= rom_word(prog_rom_addr);
        param_rom_q <= 12'h000;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: expected writes of one full sequence
    task automatic expect_boot();
        prog_exp.delete();
        param_exp.delete();
        data_exp.delete();
        for (int a = 0; a < PD; a++) prog_exp.push_back({13'd0, 3'(a), rom_word(3'(a))});
        for (int a = 0; a < QD; a++) param_exp.push_back({17'd0, 3'(a), 12'h000});
        for (int a = 0; a < DD; a++) data_exp.push_back({17'd0, 3'(a), 12'h000});
        clr_seen = 0;
    endtask

    // Monitor: pop and compare each write as it appears
    always @(negedge clk) begin
        if (track) begin
            if (prog_we) begin
                logic [31:0] e;
                logic [31:0] g;
                g = {13'd0, prog_ram_addr, prog_wdata};
                e = (prog_exp.size() > 0) ? prog_exp.pop_front() : 32'hFFFF_FFFF;
                check(g == e, "R4 program write", g, e);
            end
            if (param_we) begin
                logic [31:0] e;
                logic [31:0] g;
                g = {17'd0, param_ram_addr, param_wdata};
                e = (param_exp.size() > 0) ? param_exp.pop_front() : 32'hFFFF_FFFF;
                check(g == e, "R5 parameter write", g, e);
            end
            if (data_we) begin
                logic [31:0] e;
                logic [31:0] g;
                g = {17'd0, data_addr, data_wdata};
                e = (data_exp.size() > 0) ? data_exp.pop_front() : 32'hFFFF_FFFF;
                check(g == e, "R6 data write", g, e);
            end
            if (reg_clr) clr_seen++;
        end
    end

    // Checks from the start edge P0 (called at P0 + 1 ns)
    task automatic run_timeline(input logic [1:0] mode_exp);
        check(busy == 1'b1 && done == 1'b0, "R2 busy at start edge", {busy, done}, 2'b10);
        mode_in  = ~mode_exp;
        host_req = 1'b1;
        step(1);
        host_req = 1'b0;
        check(refused == 1'b1 && grant == 1'b0, "R8 refused while busy", {refused, grant}, 2'b10);
        step(L - 1);
        check(prog_we == 1'b0, "R3 no write at end of wait", prog_we, 0);
        check(prog_rom_addr == 3'd0, "R3 first ROM address", prog_rom_addr, 0);
        step(1);
        check(prog_we == 1'b1 && prog_ram_addr == 3'd0, "R3 first program write", {prog_we, prog_ram_addr}, 4'b1000);
        step(PD + QD - 1);
        check(reg_clr == 1'b1, "R6 clear strobe high", reg_clr, 1);
        step(1);
        check(reg_clr == 1'b0, "R6 clear strobe one cycle", reg_clr, 0);
        step(DD - 2);
        check(done == 1'b0, "R7 done not early", done, 0);
        step(1);
        check(done == 1'b1 && busy == 1'b0, "R7 done on time", {done, busy}, 2'b10);
        step(4);
        check(done == 1'b1, "R7 done stays high", done, 1);
        check(prog_exp.size() == 0, "R4 all program words", prog_exp.size(), 0);
        check(param_exp.size() == 0, "R5 all parameter words", param_exp.size(), 0);
        check(data_exp.size() == 0, "R6 all data words", data_exp.size(), 0);
        check(clr_seen == 1, "R6 one clear strobe", clr_seen, 1);
        check(mode_out == mode_exp, "R9 mode held", mode_out, mode_exp);
        host_req = 1'b1;
        step(1);
        host_req = 1'b0;
        check(grant == 1'b1 && refused == 1'b0, "R8 granted when done", {grant, refused}, 2'b10);
    endtask

    initial begin
        rst      = 1'b1;
        mode_in  = 2'b10;
        host_req = 1'b0;
        step(3);
        check(done == 1'b0 && busy == 1'b0 && reg_clr == 1'b0, "R1 reset flags", {done, busy, reg_clr}, 0);
        check(!prog_we && !param_we && !data_we, "R1 no writes in reset", {prog_we, param_we, data_we}, 0);
        host_req = 1'b1;
        step(1);
        host_req = 1'b0;
        check(refused == 1'b1 && grant == 1'b0, "R1 request refused in reset", {refused, grant}, 2'b10);

        // Run 1: release just after a rising edge
        expect_boot();
        track = 1'b1;
        rst   = 1'b0;
        step(1);
        run_timeline(2'b10);

        // Run 2: abort during the program copy
        track = 1'b0;
        rst   = 1'b1;
        step(1);
        check(done == 1'b0, "R10 reset clears done", done, 0);
        rst = 1'b0;
        step(1);
        step(L + 3);
        check(prog_we == 1'b1, "R10 copy under way before abort", prog_we, 1);
        rst = 1'b1;
        step(1);
        check(done == 1'b0 && busy == 1'b0 && prog_we == 1'b0, "R10 abort returns to reset",
              {done, busy, prog_we}, 0);
        step(2);

        // Run 3: release just after a falling edge, new clock mode
        mode_in = 2'b01;
        expect_boot();
        track = 1'b1;
        @(negedge clk);
        #1;
        rst = 1'b0;
        step(1);
        check(busy == 1'b0, "R2 falling-edge sample delays start", busy, 0);
        step(1);
        run_timeline(2'b01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule